// File: doc/BRIEF.md
# Audio Clock Control Register Slave

This block is the serial control port of an audio clock generator. It is an I2C fast-mode slave that keeps two 8-bit control registers. One register gates the three audio clock outputs and powers down the internal analog blocks. The other register picks the sampling-speed mode and the master-clock frequency. The register fields leave the block as plain decoded wires, so the clock-generation logic can use them directly.

The bus lines are sampled by a system clock that runs at least ten times faster than SCL. Each line passes through a two-flop synchroniser, and the start, stop and edge events are decoded from the synchronised copies. The slave never stretches the clock. It pulls SDA low only to acknowledge a byte or to send a 0 data bit. A register pointer survives from one transaction to the next. The pointer steps after every byte written or read, and it wraps from the last register back to the first. Because of this, a master can stream several bytes, read from the current position, or set the pointer with a short write and then turn the bus around with a repeated start.

Top module: `i2c_ctl_regs`

## Requirements
- R1: The slave answers only the 7-bit address formed by the prefix 00100 followed by `strap_a1` and then `strap_a0`. Bit 0 of the address byte is the direction: 1 for read, 0 for write. When any other address is sent, SDA is not pulled in the acknowledge slot, and the rest of that transaction leaves every register unchanged.
- R2: In a write transaction, the slave acknowledges the address byte, the register-address byte and every data byte that follows.
- R3: The first byte after a write address loads the register pointer. Each later data byte, received MSB first, is stored at the pointer, and the pointer then advances by one. Advancing past 01h wraps the pointer to 00h.
- R4: Read data is sent MSB first, and SDA changes only while SCL is low. After each byte the pointer advances and wraps from 01h to 00h. When the master acknowledges, the next byte follows. When the master does not acknowledge, the slave releases SDA and stops sending.
- R5: The pointer persists between transactions. A read that begins right after a start returns the byte at the pointer, which is the last address accessed plus one.
- R6: A write that carries only a register address, followed by a repeated start and a read address, reads from that register.
- R7: Register 00h drives three output-disable fields from bits 7, 6 and 5 (`out_lr_off`, `out_bit_off`, `out_mst_off`). It drives three power-down fields from bits 2, 1 and 0 (`pwr_ref_down`, `pwr_pll2_down`, `pwr_pll1_down`). Its reset value is E0h.
- R8: Register 01h drives `rate_mode` from bits 5:4 and `mclk_sel` from bits 1:0. Its reset value is 00h.
- R9: Unused bits read as 0 and keep 0 whatever is written to them; register 00h reads back as the written value AND E7h, and register 01h as the written value AND 33h. Addresses other than 00h and 01h read as 00h, and writes to them change nothing.
- R10: While `rst_n` is low, both registers return to their defaults, the pointer returns to 00h and SDA is released.
- R11: A stop (SDA rising while SCL is high) ends any transaction and SDA is released afterwards. A start is SDA falling while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 10x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_a1 | input | 1 | Address strap, address bit 1 |
| strap_a0 | input | 1 | Address strap, address bit 0 |
| sda_pull | output | 1 | 1 pulls SDA low |
| out_lr_off | output | 1 | Frame clock output disable |
| out_bit_off | output | 1 | Bit clock output disable |
| out_mst_off | output | 1 | Master clock output disable |
| pwr_ref_down | output | 1 | Reference power-down |
| pwr_pll2_down | output | 1 | Second PLL power-down |
| pwr_pll1_down | output | 1 | First PLL power-down |
| rate_mode | output | 2 | Sampling-speed mode select |
| mclk_sel | output | 2 | Master clock frequency select |

## Verification
The bench targets the pointer wrap on both the write path and the read path. A design that stopped at 01h, or ran on to 02h, would store the third byte of a burst in the wrong place and would return 00h where 05h is expected. A mismatched address is followed by full data bytes. This catches a slave that acknowledges a foreign address or that latches data it was never granted. Writing all ones exposes any unused bit that is kept. A write to an address outside the map, followed by a read there, exposes aliasing onto a real register. Current-address reads after bursts, and a read after a reset, expose a pointer that is not kept, or that is cleared by stop instead of by reset.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PREFIX_W  = 5;
  localparam logic [PREFIX_W-1:0] DEV_PREFIX = 5'b00100;
  localparam logic [BYTE_W-1:0] LAST_REG   = 8'h01;
  localparam logic [BYTE_W-1:0] DFLT_REG0  = 8'hE0;
  localparam logic [BYTE_W-1:0] DFLT_REG1  = 8'h00;
  localparam logic [BYTE_W-1:0] KEEP_REG0  = 8'hE7;
  localparam logic [BYTE_W-1:0] KEEP_REG1  = 8'h33;

  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_SUB, PH_WR, PH_RD} phase_t;

  function automatic logic [6:0] own_addr(input logic a1, input logic a0);
    return {DEV_PREFIX, a1, a0};
  endfunction

  function automatic logic [BYTE_W-1:0] next_ptr(input logic [BYTE_W-1:0] p);
    return (p == LAST_REG) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [BYTE_W-1:0] keep_mask(input logic [BYTE_W-1:0] a);
    case (a)
      8'h00:   return KEEP_REG0;
      8'h01:   return KEEP_REG1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int unsigned STAGES = 3;
  logic [STAGES-1:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
    end
  end

  logic scl_d, sda_d;
  assign scl_s     = scl_pipe[1];
  assign sda_s     = sda_pipe[1];
  assign scl_d     = scl_pipe[2];
  assign sda_d     = sda_pipe[2];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] reg0_q,
  output logic [BYTE_W-1:0] reg1_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg0_q <= DFLT_REG0;
      reg1_q <= DFLT_REG1;
    end else if (wr_en) begin
      if (wr_addr == 8'h00) reg0_q <= wr_data & keep_mask(8'h00);
      if (wr_addr == 8'h01) reg1_q <= wr_data & keep_mask(8'h01);
    end
  end

  always_comb begin
    case (rd_addr)
      8'h00:   rd_data = reg0_q;
      8'h01:   rd_data = reg1_q;
      default: rd_data = '0;
    endcase
  end

  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > LAST_REG) |=> ($stable(reg0_q) && $stable(reg1_q)));
  p_reset_dflt_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (reg0_q == DFLT_REG0 && reg1_q == DFLT_REG1));
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              strap_a1,
  input  logic              strap_a0,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              drive
);
  phase_t            phase;
  logic              ack_ph, rw_bit, nack_q;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg, txreg;

  logic rx_phase, byte_done, dev_hit, rd_load, ptr_step;
  assign rx_phase  = (phase == PH_DEV) || (phase == PH_SUB) || (phase == PH_WR);
  assign byte_done = rx_phase && !ack_ph && scl_fall && (bitcnt == 4'd8);
  assign dev_hit   = (shreg[7:1] == own_addr(strap_a1, strap_a0));
  assign wr_en     = byte_done && (phase == PH_WR);
  assign wr_data   = shreg;
  assign rd_load   = ack_ph && scl_fall &&
                     (((phase == PH_DEV) && rw_bit) || ((phase == PH_RD) && !nack_q));
  assign ptr_step  = wr_en || rd_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; ack_ph <= 1'b0; rw_bit <= 1'b0; nack_q <= 1'b0;
      bitcnt <= '0; shreg <= '0; txreg <= '0; ptr <= '0; drive <= 1'b0;
    end else if (start_evt) begin
      phase <= PH_DEV; ack_ph <= 1'b0; bitcnt <= '0; drive <= 1'b0;
    end else if (stop_evt) begin
      phase <= PH_IDLE; ack_ph <= 1'b0; drive <= 1'b0;
    end else if (rx_phase && !ack_ph) begin
      if (scl_rise) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (byte_done) begin
        if (phase == PH_DEV && !dev_hit) begin
          phase <= PH_IDLE;
        end else begin
          ack_ph <= 1'b1;
          drive  <= 1'b1;
          if (phase == PH_DEV) rw_bit <= shreg[0];
          if (phase == PH_SUB) ptr <= shreg;
          if (phase == PH_WR)  ptr <= next_ptr(ptr);
        end
      end
    end else if (rx_phase && ack_ph) begin
      if (scl_fall) begin
        ack_ph <= 1'b0;
        bitcnt <= '0;
        drive  <= 1'b0;
        if (rd_load) begin
          phase <= PH_RD;
          txreg <= rd_data;
          drive <= ~rd_data[7];
          ptr   <= next_ptr(ptr);
        end else if (phase == PH_DEV) begin
          phase <= PH_SUB;
        end else begin
          phase <= PH_WR;
        end
      end
    end else if (phase == PH_RD && !ack_ph) begin
      if (scl_fall) begin
        if (bitcnt == 4'd7) begin
          drive  <= 1'b0;
          ack_ph <= 1'b1;
          bitcnt <= '0;
        end else begin
          txreg  <= {txreg[6:0], 1'b0};
          drive  <= ~txreg[6];
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end else if (phase == PH_RD && ack_ph) begin
      if (scl_rise) nack_q <= sda_s;
      if (scl_fall) begin
        ack_ph <= 1'b0;
        if (rd_load) begin
          txreg <= rd_data;
          drive <= ~rd_data[7];
          ptr   <= next_ptr(ptr);
        end else begin
          phase <= PH_IDLE;
        end
      end
    end
  end

  p_foreign_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DEV && !dev_hit) |=> (!drive && phase == PH_IDLE));
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr == LAST_REG) |=> (ptr == 8'h00));
  p_sda_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive) |-> !scl_s);
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !drive);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !drive);
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       strap_a1,
  input  logic       strap_a0,
  output logic       sda_pull,
  output logic       out_lr_off,
  output logic       out_bit_off,
  output logic       out_mst_off,
  output logic       pwr_ref_down,
  output logic       pwr_pll2_down,
  output logic       pwr_pll1_down,
  output logic [1:0] rate_mode,
  output logic [1:0] mclk_sel
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data, reg0_q, reg1_q;

  i2c_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_slave_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_a1(strap_a1), .strap_a0(strap_a0), .rd_data(rd_data),
    .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data), .drive(sda_pull)
  );

  ctl_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .reg0_q(reg0_q), .reg1_q(reg1_q)
  );

  assign out_lr_off    = reg0_q[7];
  assign out_bit_off   = reg0_q[6];
  assign out_mst_off   = reg0_q[5];
  assign pwr_ref_down  = reg0_q[2];
  assign pwr_pll2_down = reg0_q[1];
  assign pwr_pll1_down = reg0_q[0];
  assign rate_mode     = reg1_q[5:4];
  assign mclk_sel      = reg1_q[1:0];
endmodule

// File: tb/tb_i2c_ctl_regs.sv
module tb_i2c_ctl_regs;
  localparam int Q = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic a1 = 1'b1, a0 = 1'b0;
  logic sda_pull, lr_off, bit_off, mst_off, ref_dn, pll2_dn, pll1_dn;
  logic [1:0] rate_mode, mclk_sel;
  logic sda_bus;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .strap_a1(a1), .strap_a0(a0), .sda_pull(sda_pull),
    .out_lr_off(lr_off), .out_bit_off(bit_off), .out_mst_off(mst_off),
    .pwr_ref_down(ref_dn), .pwr_pll2_down(pll2_dn), .pwr_pll1_down(pll1_dn),
    .rate_mode(rate_mode), .mclk_sel(mclk_sel)
  );

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] field_byte0();
    return {lr_off, bit_off, mst_off, 2'b00, ref_dn, pll2_dn, pll1_dn};
  endfunction
  function automatic logic [7:0] field_byte1();
    return {2'b00, rate_mode, 2'b00, mclk_sel};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    chk("R11 sda released after stop", sda_pull, 1'b0);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q/2);
    @(negedge clk); acked = ~sda_bus;
    wt(Q/2); scl = 1'b0; wt(2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q/2);
      @(negedge clk); b[i] = sda_bus;
      wt(Q/2); scl = 1'b0; wt(2);
    end
    sda_m = ~mack; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {5'b00100, a1, a0, rd};
  endfunction

  task automatic rand_read1(input logic [7:0] sub, output logic [7:0] d);
    logic k;
    bus_start(); send_byte(dev(1'b0), k); send_byte(sub, k);
    bus_start(); send_byte(dev(1'b1), k);
    recv_byte(1'b0, d); bus_stop();
  endtask

  task automatic t_reset_state();
    chk("R10 sda idle at reset", sda_pull, 1'b0);
    chk("R7 reg00 default E0", field_byte0(), 8'hE0);
    chk("R8 reg01 default 00", field_byte1(), 8'h00);
  endtask

  task automatic t_write_all_ones();
    logic k0, k1, k2; logic [7:0] d;
    bus_start(); send_byte(dev(1'b0), k0); send_byte(8'h00, k1); send_byte(8'hFF, k2); bus_stop();
    chk("R1 own address acked", k0, 1'b1);
    chk("R2 sub address acked", k1, 1'b1);
    chk("R2 data acked", k2, 1'b1);
    chk("R7 fields after FF", field_byte0(), 8'hE7);
    rand_read1(8'h00, d);
    chk("R9 R6 reserved bits read 0", d, 8'hE7);
  endtask

  task automatic t_foreign_addr();
    logic k0, k1;
    bus_start(); send_byte({5'b00100, 2'b11, 1'b0}, k0);
    send_byte(8'h00, k1); send_byte(8'h00, k1); bus_stop();
    chk("R1 foreign address not acked", k0, 1'b0);
    chk("R1 foreign write ignored", field_byte0(), 8'hE7);
  endtask

  task automatic t_burst_wrap();
    logic k; logic [7:0] d;
    bus_start(); send_byte(dev(1'b0), k); send_byte(8'h01, k);
    send_byte(8'h31, k); send_byte(8'h05, k); send_byte(8'hAA, k); bus_stop();
    chk("R3 R8 reg01 after wrap", field_byte1(), 8'h22);
    chk("R3 R7 reg00 via wrap", field_byte0(), 8'h05);
    chk("R8 rate_mode field", rate_mode, 2'd2);
    // pointer wrapped back to 00h after third byte
    bus_start(); send_byte(dev(1'b1), k); recv_byte(1'b0, d); bus_stop();
    chk("R5 current read at 00", d, 8'h05);
  endtask

  task automatic t_read_wrap();
    logic k; logic [7:0] d0, d1;
    bus_start(); send_byte(dev(1'b1), k);
    chk("R1 read address acked", k, 1'b1);
    recv_byte(1'b1, d0); recv_byte(1'b0, d1); bus_stop();
    chk("R4 R5 first read at 01", d0, 8'h22);
    chk("R4 read wraps to 00", d1, 8'h05);
  endtask

  task automatic t_out_of_range();
    logic k; logic [7:0] d;
    bus_start(); send_byte(dev(1'b0), k); send_byte(8'h07, k); send_byte(8'hFF, k); bus_stop();
    chk("R2 data to unmapped acked", k, 1'b1);
    chk("R9 unmapped write no effect 00", field_byte0(), 8'h05);
    chk("R9 unmapped write no effect 01", field_byte1(), 8'h22);
    rand_read1(8'h07, d);
    chk("R9 unmapped read 00", d, 8'h00);
  endtask

  task automatic t_strap_change();
    logic [7:0] d;
    a1 = 1'b0; a0 = 1'b1; wt(4);
    rand_read1(8'h01, d);
    chk("R1 R6 new strap random read", d, 8'h22);
  endtask

  task automatic t_reset_again();
    logic k; logic [7:0] d;
    rst_n = 1'b0; wt(3);
    chk("R10 sda released in reset", sda_pull, 1'b0);
    rst_n = 1'b1; wt(3);
    chk("R10 reg00 restored", field_byte0(), 8'hE0);
    chk("R10 reg01 restored", field_byte1(), 8'h00);
    bus_start(); send_byte(dev(1'b1), k); recv_byte(1'b0, d); bus_stop();
    chk("R10 R5 pointer back to 00", d, 8'hE0);
  endtask

  initial begin
    wt(5);
    t_reset_state();
    rst_n = 1'b1; wt(5);
    t_write_all_ones();
    t_foreign_addr();
    t_burst_wrap();
    t_read_wrap();
    t_out_of_range();
    t_strap_change();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule